// File: doc/BRIEF.md
# Interleaved Dual-Channel ADC Demultiplexer

This block sits behind a dual-channel 8-bit converter whose two channels share one data bus. The converter samples both channels together on the rising edge of its clock. It then drives the channel A result onto the bus while the clock is high and the channel B result while the clock is low. A channel-indicator line is high during the A half and low during the B half. It trails the clock by a few nanoseconds, so it is sampled late in each half-period, where it has settled.

The block captures the A word and its indicator on the falling edge. It captures the B word and its indicator on the next rising edge. It retimes both into the rising-edge domain and pairs each A word with the B word that follows it half a cycle later. The converter gives B half a cycle more latency than A, so this pairing brings together two words taken at the same sampling instant. Each pair is checked against the indicator and may be converted from offset binary to two's complement. It is presented on registered outputs with a valid strobe. A pair whose indicator levels are wrong raises a sync error instead.

Top module: `adc_pair_demux`

## Requirements
- R1: While reset is high at a rising edge, `pair_valid`, `sync_err`, `pair_a` and `pair_b` are all 0 after that edge. On the first rising edge with reset low, `pair_valid` and `sync_err` stay 0.
- R2: The word held on `bus_data` at the falling edge of cycle j appears on `pair_a` after rising edge j+2. Cycle j starts at rising edge j.
- R3: The word held on `bus_data` at rising edge j+1 appears on `pair_b` after rising edge j+2, in the same cycle as the A word of R2.
- R4: A pair is well ordered when `chan_ind` is 1 at its falling-edge capture and 0 at its rising-edge capture. A pair that is not well ordered gives `sync_err`=1 and `pair_valid`=0 in its output cycle.
- R5: A well-ordered pair gives `sync_err`=0 in its output cycle.
- R6: When `fmt_twos`=0 at the output edge, the words pass unchanged in offset binary. When it is 1, bit 7 of each word is inverted: 0x00 becomes 0x80, 0x80 becomes 0x00, 0xFF becomes 0x7F and 0x7F becomes 0xFF.
- R7: After reset is released, `pair_valid` stays 0 until at least WARMUP rising edges have passed (default 6) and an earlier well-ordered pair has been seen.
- R8: Once armed, every well-ordered pair gives `pair_valid`=1, and `pair_valid` and `sync_err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Shared converter output bus |
| chan_ind | input | 1 | Channel indicator, 1 during the A half and 0 during the B half |
| fmt_twos | input | 1 | 1 selects two's complement output, 0 selects offset binary |
| pair_valid | output | 1 | Aligned pair present on the outputs |
| sync_err | output | 1 | Indicator order was wrong for this pair |
| pair_a | output | 8 | Channel A word |
| pair_b | output | 8 | Channel B word from the same sampling instant |

## Verification
Two things can fall on the same output edge: a pair with a bad indicator level, and the edge on which the warm-up count completes and the block would arm. The bench sets up this collision after a second reset. It corrupts the indicator on the pairs around the end of warm-up, then sends good pairs. A bench model tracks the warm-up count and whether a good pair has been seen. It requires `sync_err` on the corrupted pairs, `pair_valid` low on them, and arming only from the first good pair after that. Random indicator faults and format switching across a long run make both events, and format changes, land together on many other edges as well.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;
  localparam int unsigned CHANNELS = 2;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;

  typedef enum logic {
    LANE_A = 1'b0,
    LANE_B = 1'b1
  } lane_e;
endpackage

// File: rtl/adc_edge_capture.sv
module adc_edge_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              chan_ind,
  output logic              st_vld,
  output logic [DATA_W-1:0] st_a,
  output logic [DATA_W-1:0] st_b,
  output logic              st_a_ind,
  output logic              st_b_ind
);
  // falling-edge capture: end of the high half, where the A word sits
  logic [DATA_W-1:0] hi_word;
  logic              hi_ind;

  always_ff @(negedge clk) begin
    if (rst) begin
      hi_word <= '0;
      hi_ind  <= 1'b0;
    end else begin
      hi_word <= bus_data;
      hi_ind  <= chan_ind;
    end
  end

  // rising-edge stage: retimed A word plus the B word from the low half
  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld   <= 1'b0;
      st_a     <= '0;
      st_b     <= '0;
      st_a_ind <= 1'b0;
      st_b_ind <= 1'b0;
    end else begin
      st_vld   <= 1'b1;
      st_a     <= hi_word;
      st_a_ind <= hi_ind;
      st_b     <= bus_data;
      st_b_ind <= chan_ind;
    end
  end
endmodule

// File: rtl/adc_pair_check.sv
module adc_pair_check #(
  parameter int unsigned WARMUP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic st_vld,
  input  logic st_a_ind,
  input  logic st_b_ind,
  output logic emit,
  output logic fault
);
  localparam int unsigned CNT_W = $clog2(WARMUP + 1);

  logic [CNT_W-1:0] warm_cnt;
  logic             seen_good;
  logic             ordered;
  logic             warm_done;

  assign ordered   = st_a_ind & ~st_b_ind;
  assign warm_done = (warm_cnt == CNT_W'(WARMUP));

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_cnt <= '0;
    end else if (!warm_done) begin
      warm_cnt <= warm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_good <= 1'b0;
    end else if (st_vld && ordered) begin
      seen_good <= 1'b1;
    end
  end

  assign emit  = st_vld & ordered & warm_done & seen_good;
  assign fault = st_vld & ~ordered;
endmodule

// File: rtl/adc_word_format.sv
module adc_word_format
  import adc_demux_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] raw,
  input  fmt_e              mode,
  output logic [DATA_W-1:0] cooked
);
  always_comb begin
    cooked = raw;
    if (mode == FMT_TWOS) begin
      cooked[DATA_W-1] = ~raw[DATA_W-1];
    end
  end
endmodule

// File: rtl/adc_pair_demux.sv
module adc_pair_demux
  import adc_demux_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WARMUP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              chan_ind,
  input  logic              fmt_twos,
  output logic              pair_valid,
  output logic              sync_err,
  output logic [DATA_W-1:0] pair_a,
  output logic [DATA_W-1:0] pair_b
);
  logic              st_vld;
  logic [DATA_W-1:0] st_a;
  logic [DATA_W-1:0] st_b;
  logic              st_a_ind;
  logic              st_b_ind;
  logic              emit;
  logic              fault;

  logic [DATA_W-1:0] lane_raw [CHANNELS];
  logic [DATA_W-1:0] lane_fmt [CHANNELS];

  adc_edge_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .bus_data (bus_data),
    .chan_ind (chan_ind),
    .st_vld   (st_vld),
    .st_a     (st_a),
    .st_b     (st_b),
    .st_a_ind (st_a_ind),
    .st_b_ind (st_b_ind)
  );

  adc_pair_check #(.WARMUP(WARMUP)) u_chk_logic (
    .clk      (clk),
    .rst      (rst),
    .st_vld   (st_vld),
    .st_a_ind (st_a_ind),
    .st_b_ind (st_b_ind),
    .emit     (emit),
    .fault    (fault)
  );

  assign lane_raw[LANE_A] = st_a;
  assign lane_raw[LANE_B] = st_b;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    adc_word_format #(.DATA_W(DATA_W)) u_fmt (
      .raw    (lane_raw[ch]),
      .mode   (fmt_e'(fmt_twos)),
      .cooked (lane_fmt[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_valid <= 1'b0;
      sync_err   <= 1'b0;
      pair_a     <= '0;
      pair_b     <= '0;
    end else begin
      pair_valid <= emit;
      sync_err   <= fault;
      pair_a     <= lane_fmt[LANE_A];
      pair_b     <= lane_fmt[LANE_B];
    end
  end
endmodule

// File: rtl/adc_pair_demux_checker.sv
module adc_pair_demux_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WARMUP = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              fmt_twos,
  input logic              pair_valid,
  input logic              sync_err,
  input logic [DATA_W-1:0] pair_a,
  input logic [DATA_W-1:0] pair_b,
  input logic              st_vld,
  input logic [DATA_W-1:0] st_a,
  input logic [DATA_W-1:0] st_b,
  input logic              st_a_ind,
  input logic              st_b_ind
);
  localparam int unsigned CNT_W = $clog2(WARMUP + 1);
  localparam int unsigned MSB   = DATA_W - 1;

  logic [CNT_W-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (since_rst != CNT_W'(WARMUP)) begin
      since_rst <= since_rst + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pair_valid && !sync_err));

  assert_lane_a_path_R2: assert property (@(posedge clk) disable iff (rst)
    st_vld |=> (pair_a[MSB-1:0] == $past(st_a[MSB-1:0])));

  assert_lane_b_path_R3: assert property (@(posedge clk) disable iff (rst)
    st_vld |=> (pair_b[MSB-1:0] == $past(st_b[MSB-1:0])));

  assert_bad_order_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (st_vld && !(st_a_ind && !st_b_ind)) |=> (sync_err && !pair_valid));

  assert_good_order_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (st_vld && st_a_ind && !st_b_ind) |=> !sync_err);

  assert_msb_format_R6: assert property (@(posedge clk) disable iff (rst)
    st_vld |=> ((pair_a[MSB] == ($past(st_a[MSB]) ^ $past(fmt_twos))) &&
                (pair_b[MSB] == ($past(st_b[MSB]) ^ $past(fmt_twos)))));

  assert_warmup_hold_R7: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (since_rst == CNT_W'(WARMUP)));

  assert_exclusive_flags_R8: assert property (@(posedge clk) disable iff (rst)
    !(pair_valid && sync_err));
endmodule

bind adc_pair_demux adc_pair_demux_checker #(
  .DATA_W (DATA_W),
  .WARMUP (WARMUP)
) u_assert (
  .clk        (clk),
  .rst        (rst),
  .fmt_twos   (fmt_twos),
  .pair_valid (pair_valid),
  .sync_err   (sync_err),
  .pair_a     (pair_a),
  .pair_b     (pair_b),
  .st_vld     (st_vld),
  .st_a       (st_a),
  .st_b       (st_b),
  .st_a_ind   (st_a_ind),
  .st_b_ind   (st_b_ind)
);

// File: tb/adc_pair_demux_test.sv
module adc_pair_demux_test;
  localparam int WARM = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = 8'h00;
  logic       chan_ind = 1'b0;
  logic       fmt_twos = 1'b0;
  logic       pair_valid;
  logic       sync_err;
  logic [7:0] pair_a;
  logic [7:0] pair_b;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int r0 = 0;
  bit seen_m = 0;
  bit done = 0;

  logic [7:0] a_h [8];
  logic [7:0] b_h [8];
  logic       ia_h [8];
  logic       ib_h [8];
  logic       f_h [8];

  always #4 clk = ~clk;

  adc_pair_demux #(.DATA_W(8), .WARMUP(WARM)) uut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .chan_ind(chan_ind),
    .fmt_twos(fmt_twos), .pair_valid(pair_valid), .sync_err(sync_err),
    .pair_a(pair_a), .pair_b(pair_b)
  );

  function automatic logic [7:0] fmt_word(input logic [7:0] w, input logic f);
    return f ? (w ^ 8'h80) : w;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic check_outputs();
    int j;
    bit ok;
    if (rst) begin
      seen_m = 0;
      chk("R1 valid", {7'd0, pair_valid}, 8'd0);
      chk("R1 err", {7'd0, sync_err}, 8'd0);
      chk("R1 a", pair_a, 8'd0);
      chk("R1 b", pair_b, 8'd0);
    end else if (cyc == r0) begin
      chk("R1 first valid", {7'd0, pair_valid}, 8'd0);
      chk("R1 first err", {7'd0, sync_err}, 8'd0);
    end else if (cyc > r0) begin
      j = cyc - 2;
      ok = ia_h[j%8] && !ib_h[j%8];
      chk("R2 pair_a", pair_a, fmt_word(a_h[j%8], f_h[(j+1)%8]));
      chk("R3 pair_b", pair_b, fmt_word(b_h[j%8], f_h[(j+1)%8]));
      if (ok) chk("R5 err", {7'd0, sync_err}, 8'd0);
      else    chk("R4 err", {7'd0, sync_err}, 8'd1);
      if (!ok) chk("R4 valid", {7'd0, pair_valid}, 8'd0);
      else if ((cyc - r0) >= WARM && seen_m) chk("R8 valid", {7'd0, pair_valid}, 8'd1);
      else chk("R7 valid", {7'd0, pair_valid}, 8'd0);
      seen_m = seen_m | ok;
    end
  endtask

  task automatic step(input logic [7:0] a, input logic ia, input logic [7:0] b,
                      input logic ib, input logic f, input logic r);
    @(posedge clk);
    cyc++;
    #1;
    check_outputs();
    if (rst && !r) r0 = cyc + 1;
    rst = r;
    bus_data = a;
    chan_ind = ia;
    fmt_twos = f;
    a_h[cyc%8] = a;
    ia_h[cyc%8] = ia;
    f_h[cyc%8] = f;
    @(negedge clk);
    #1;
    bus_data = b;
    chan_ind = ib;
    b_h[cyc%8] = b;
    ib_h[cyc%8] = ib;
  endtask

  initial begin
    logic [7:0] corner [6];
    logic f;
    corner[0] = 8'h00; corner[1] = 8'h80; corner[2] = 8'hFF;
    corner[3] = 8'h7F; corner[4] = 8'h01; corner[5] = 8'hFE;
    void'($urandom(32'd20240517));
    for (int i = 0; i < 5; i++) step(8'h55, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b1);
    // directed corners, both formats (R6)
    for (int i = 0; i < 24; i++)
      step(corner[i%6], 1'b1, corner[(i+3)%6], 1'b0, i[3], 1'b0);
    // random run with occasional indicator faults
    f = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      if (i % 8 == 0) f = $urandom_range(0, 1) == 1;
      step($urandom_range(0, 255), $urandom_range(0, 9) != 0,
           $urandom_range(0, 255), $urandom_range(0, 9) == 0, f, 1'b0);
    end
    // second reset, then faults right at the end of warm-up (R7 with R4)
    for (int i = 0; i < 3; i++) step(8'h11, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(8'h30 + 8'(i), 1'b1, 8'hC0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(8'h40, 1'b0, 8'hB0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step(8'h80 + 8'(i), 1'b1, 8'h7F - 8'(i), 1'b0, 1'b0, 1'b0);
    step(8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    step(8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule